// File: doc/BRIEF.md
# Three-Bank Non-Power-of-Two RAM

This block is a single-port memory whose usable depth is three banks of equal size rather than the full power of two that its address width spans. With the default parameters the address is 12 bits wide and each bank holds 1024 words of 8 bits. That gives 3072 words of storage, and no storage exists for the fourth quarter of the address space. The two most significant address bits pick a bank, and the remaining bits index a word inside it. The mapping runs downward: the highest select code reaches the first bank.

Each clock cycle is one access. The input word is always written into the selected bank at the indexed location. The word previously held there comes back on the output one cycle later (read-before-write). When the select code is zero, no bank is touched. The input word is then simply returned one cycle later, so all four cases share the same one-cycle latency. An active-low asynchronous reset clears only the output pipeline, never the memory contents.

Top module: `ram3_nonpow2`

## Requirements
- R1: While reset is asserted the output `dout` is all zeros, whatever `din` and `addr` carry.
- R2: The select code is `addr[ADDR_W-1:ADDR_W-2]`. Code 2'b11 reaches bank 0, 2'b10 reaches bank 1 and 2'b01 reaches bank 2. At most one bank is enabled per cycle, and the three banks hold separate words for the same low index.
- R3: A mapped access stores `din` at the indexed word of the selected bank. One clock later, `dout` shows the word that location held before that write.
- R4: With select code 2'b00, `dout` equals the `din` of the previous cycle and no bank is written.
- R5: A bank that is not selected in a cycle keeps all its words and its read register unchanged.
- R6: Back-to-back accesses to the same location return, on each access, the word written by the access just before it.
- R7: The output source follows the select code registered in the previous cycle, so alternating between banks and the unmapped code returns each result from the right source.
- R8: The low `BANK_AW` address bits index `2**BANK_AW` distinct words in each bank, giving `3*2**BANK_AW` words in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the output pipeline |
| addr | input | BANK_AW+2 | Bank select code in the top two bits, word index below |
| din | input | DATA_W | Word written on a mapped access, returned on an unmapped one |
| dout | output | DATA_W | Registered result of the access one cycle earlier |

## Verification
The bench builds the block with `DATA_W` = 8 and `BANK_AW` = 4, so each bank has 16 words. This makes it cheap to fill every word of all three banks and then read each one back, which exercises the complete index decode and shows that the banks do not alias one another. With the same narrow index, the same low index can be hit in every bank and in the unmapped quarter within a few cycles. This covers the inverted select order, the passthrough path and the back-to-back read-before-write sequences.

// File: rtl/ram3_pkg.sv
package ram3_pkg;

    localparam int SEL_W     = 2;
    localparam int NUM_BANKS = (1 << SEL_W) - 1;

    // Select code owned by bank b: highest code maps to bank 0.
    function automatic logic [SEL_W-1:0] bank_code(input int b);
        return SEL_W'(NUM_BANKS - b);
    endfunction

endpackage

// File: rtl/ram3_decode.sv
module ram3_decode
    import ram3_pkg::*;
(
    input  logic [SEL_W-1:0]     code,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic                 pass
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
        assign bank_en[b] = (code == bank_code(b));
    end

    assign pass = (code == '0);

endmodule

// File: rtl/ram3_bank.sv
module ram3_bank #(
    parameter int DATA_W  = 8,
    parameter int BANK_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [BANK_AW-1:0] idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << BANK_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            mem[idx] <= wdata;
            rdata_q  <= mem[idx];
        end
    end

    assign rdata = rdata_q;

    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (mem[$past(idx)] === $past(wdata)));

    p_rbw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (rdata_q === $past(mem[idx])));

    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (mem[$past(idx)] === $past(mem[idx])));

    p_hold_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (rdata_q === $past(rdata_q)));

endmodule

// File: rtl/ram3_nonpow2.sv
module ram3_nonpow2
    import ram3_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BANK_AW = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BANK_AW+SEL_W-1:0]   addr,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout
);

    localparam int ADDR_W = BANK_AW + SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] pass;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [SEL_W-1:0]     code;
    logic [BANK_AW-1:0]   idx;
    logic [NUM_BANKS-1:0] bank_en;
    logic                 pass_sel;
    logic [DATA_W-1:0]    rdata [NUM_BANKS];

    assign code = addr[ADDR_W-1 -: SEL_W];
    assign idx  = addr[BANK_AW-1:0];

    ram3_decode u_dec (
        .code    (code),
        .bank_en (bank_en),
        .pass    (pass_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ram3_bank #(
            .DATA_W  (DATA_W),
            .BANK_AW (BANK_AW)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[b]),
            .idx   (idx),
            .wdata (din),
            .rdata (rdata[b])
        );
    end

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.sel  = code;
        pipe_d.pass = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        dout = pipe_q.pass;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (pipe_q.sel == bank_code(b)) begin
                dout = rdata[b];
            end
        end
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en));

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_sel |-> (bank_en == '0));

    p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |=> (dout == $past(din)));

endmodule

// File: tb/tb_ram3_nonpow2.sv
module tb_ram3_nonpow2;

    localparam int DATA_W  = 8;
    localparam int BANK_AW = 4;
    localparam int ADDR_W  = BANK_AW + 2;
    localparam int DEPTH   = 1 << BANK_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;

    int nchecks = 0;
    int nerrors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] v;
        bit                chk;
        string             tag;
    } item_t;

    item_t exp_q[$];

    logic [DATA_W-1:0] mdl   [3][DEPTH];
    bit                known [3][DEPTH];

    always #5 clk = ~clk;

    ram3_nonpow2 #(.DATA_W(DATA_W), .BANK_AW(BANK_AW)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .din   (din),
        .dout  (dout)
    );

    task automatic access(input logic [1:0] code, input int ix,
                          input logic [DATA_W-1:0] val, input string tag);
        item_t it;
        int    b;
        @(negedge clk);
        addr = {code, BANK_AW'(ix)};
        din  = val;
        it.tag = tag;
        if (code == 2'b00) begin
            it.v   = val;
            it.chk = 1'b1;
        end else begin
            b         = 3 - int'(code);
            it.v      = mdl[b][ix];
            it.chk    = known[b][ix];
            mdl[b][ix]   = val;
            known[b][ix] = 1'b1;
        end
        exp_q.push_back(it);
    endtask

    task automatic check_now(input string tag, input logic [DATA_W-1:0] expv);
        nchecks++;
        if (dout !== expv) begin
            nerrors++;
            $display("FAIL %s: dout=%h expected=%h", tag, dout, expv);
        end
    endtask

    // monitor: one result per clock, sampled away from the edges
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && exp_q.size() > 0) begin
                it = exp_q.pop_front();
                if (it.chk) check_now(it.tag, it.v);
            end
        end
    end

    initial begin
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < DEPTH; i++) known[b][i] = 1'b0;

        // R1: reset clears the output even with live inputs
        repeat (2) @(negedge clk);
        check_now("R1", '0);
        din  = 8'hA5;
        addr = '0;
        @(negedge clk);
        check_now("R1", '0);
        din = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8: fill every word of all three banks
        for (int c = 3; c >= 1; c--)
            for (int i = 0; i < DEPTH; i++)
                access(2'(c), i, 8'(c * 40 + i * 3 + 1), "R8");
        // R8: read every word back, rewriting it
        for (int c = 3; c >= 1; c--)
            for (int i = 0; i < DEPTH; i++)
                access(2'(c), i, 8'(c * 17 + i * 5 + 2), "R8");

        // R2: same low index in every bank, distinct words
        access(2'b11, 5, 8'h11, "R2");
        access(2'b10, 5, 8'h22, "R2");
        access(2'b01, 5, 8'h33, "R2");
        access(2'b11, 5, 8'h44, "R2");
        access(2'b10, 5, 8'h55, "R2");
        access(2'b01, 5, 8'h66, "R2");

        // R3 / R6: back-to-back same location
        access(2'b11, 7, 8'hA1, "R3");
        access(2'b11, 7, 8'hA2, "R6");
        access(2'b11, 7, 8'hA3, "R6");
        access(2'b01, 15, 8'hB1, "R3");
        access(2'b01, 15, 8'hB2, "R6");

        // R4: passthrough, then confirm nothing was stored
        access(2'b00, 7, 8'h3C, "R4");
        access(2'b00, 0, 8'hFF, "R4");
        access(2'b11, 7, 8'h01, "R4");
        access(2'b10, 7, 8'h02, "R4");
        access(2'b01, 7, 8'h03, "R4");

        // R7: alternate between banks and the unmapped code
        access(2'b10, 1, 8'hC1, "R7");
        access(2'b00, 1, 8'hC2, "R7");
        access(2'b01, 1, 8'hC3, "R7");
        access(2'b00, 1, 8'hC4, "R7");
        access(2'b11, 1, 8'hC5, "R7");
        access(2'b10, 1, 8'hC6, "R7");

        // R5: hammer bank 0, then verify the other banks at that index
        access(2'b11, 9, 8'hD1, "R5");
        access(2'b11, 9, 8'hD2, "R5");
        access(2'b11, 9, 8'hD3, "R5");
        access(2'b10, 9, 8'hD4, "R5");
        access(2'b01, 9, 8'hD5, "R5");

        access(2'b00, 0, 8'h00, "R4");
        @(negedge clk);
        addr = '0;
        din  = '0;
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nerrors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

endmodule